// File: doc/BRIEF.md
# Dual-Rate Burst Memory Front End

This block models a burst memory with a separate read port and write port. Each port has its own data path, so the data buses never change direction. A single multiplexed address bus serves both ports. The core clock runs at twice the memory cycle rate. An internal phase bit splits each memory cycle into a primary beat and a secondary beat. The read address is taken on the primary beat, and the write address is taken on the secondary beat of the same cycle. Every access moves two words, one per beat. Each write word carries its own active-low byte enables.

A read can be returned with a short latency (one memory cycle) or a long latency (one and a half memory cycles), chosen by a mode input. A read that hits the write issued in the previous memory cycle gets the newest data. The merge is byte by byte, because that write may still be waiting to reach the array. A valid flag stands in for the tri-stated output bus. A strobe toggles on every valid beat so that a capturing agent can align to the data.

Top module: `qdr_burst_sram`

## Requirements
- R1: After reset, `rvalid`, `rdata` and `rstrobe` are all zero. `beat_k` is high, so the first clock edge after release is a primary beat. Every array location reads back as zero.
- R2: `beat_k` toggles on every clock edge. Primary (high) and secondary (low) beats alternate.
- R3: `rd_sel_n` low at a primary beat starts a read of the location on `addr`. Word 0 and then word 1 of that location appear on two consecutive beats with `rvalid` high.
- R4: With `lat_long` low, word 0 appears after the 2nd edge following the read's primary beat. With `lat_long` high, it appears after the 3rd edge.
- R5: `wr_sel_n` low at a primary beat starts a write. Word 0 and its byte enables are taken at that beat. The address, word 1 and word 1's enables are taken at the next (secondary) beat. Bit i of `wbe_n` is active low and covers `wdata[9i+8:9i]`. Disabled bytes keep their old contents.
- R6: A read that targets the address of the write from the previous memory cycle returns that write's enabled bytes. All other bytes come from the array.
- R7: A write issued in the same memory cycle as a read does not affect that read. It is visible to reads from the next cycle onward.
- R8: Both selects are ignored at secondary beats. Driving them low there starts no access.
- R9: On beats that carry no read data, `rvalid` is low and `rdata` is zero. This includes the beats following a cycle with no read.
- R10: `rstrobe` inverts on each beat with `rvalid` high and holds its value otherwise.
- R11: A read and a write to different addresses in the same memory cycle both complete without interfering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the memory cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lat_long | input | 1 | Read latency select: 1 = 1.5 cycles, 0 = 1 cycle (hold static outside reset) |
| rd_sel_n | input | 1 | Active-low read select, sampled at primary beats |
| wr_sel_n | input | 1 | Active-low write select, sampled at primary beats |
| addr | input | ADDR_W | Read address at primary beats, write address at secondary beats |
| wdata | input | WORD_W | Write word 0 at the primary beat, word 1 at the secondary beat |
| wbe_n | input | NBYTE | Active-low byte enables for the write word on the same beat |
| rdata | output | WORD_W | Read word, zero when not valid |
| rvalid | output | 1 | Read data valid for this beat |
| rstrobe | output | 1 | Toggles with every valid read beat |
| beat_k | output | 1 | High when the next clock edge is a primary beat |

## Verification
The hardest case to reach is a read that hits a write still waiting to commit, where only some bytes of each word are enabled. The array holds older data at that moment, so a missing or wrong merge shows up only in the disabled bytes. The sweep sends the previous cycle's write address back as the read address every third cycle, and it cycles through every byte-enable combination for both words. It also includes same-cycle read/write collisions and stray selects on secondary beats. A running byte-accurate model predicts every output beat under both latency settings.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

  // Beat position inside one memory cycle.
  typedef enum logic {
    BEAT_PRI = 1'b0,
    BEAT_SEC = 1'b1
  } beat_e;

  // Word slot inside a two-word burst.
  typedef enum logic {
    SLOT_W0 = 1'b0,
    SLOT_W1 = 1'b1
  } slot_e;

endpackage

// File: rtl/qdr_phase.sv
module qdr_phase
  import qdr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic is_pri
);

  beat_e beat_q;
  beat_e beat_d;

  always_comb begin
    beat_d = (beat_q == BEAT_PRI) ? BEAT_SEC : BEAT_PRI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= BEAT_PRI;
    else        beat_q <= beat_d;
  end

  assign is_pri = (beat_q == BEAT_PRI);

endmodule

// File: rtl/qdr_wr_stage.sv
module qdr_wr_stage #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     is_pri,
  input  logic                     wr_sel_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W*NBYTE-1:0]  wdata,
  input  logic [NBYTE-1:0]         wbe_n,
  output logic                     pend_v,
  output logic [ADDR_W-1:0]        pend_addr,
  output logic [BYTE_W*NBYTE-1:0]  pend_w0,
  output logic [BYTE_W*NBYTE-1:0]  pend_w1,
  output logic [NBYTE-1:0]         pend_m0,
  output logic [NBYTE-1:0]         pend_m1
);

  localparam int WORD_W = BYTE_W * NBYTE;

  logic              act_q, act_d;
  logic [WORD_W-1:0] hw0_q, hw0_d;
  logic [NBYTE-1:0]  hm0_q, hm0_d;

  logic              pv_d;
  logic [ADDR_W-1:0] pa_d;
  logic [WORD_W-1:0] pw0_d, pw1_d;
  logic [NBYTE-1:0]  pm0_d, pm1_d;

  // Primary beat: word 0 is held. Secondary beat: the burst is completed into the pending slot.
  always_comb begin
    act_d = act_q;
    hw0_d = hw0_q;
    hm0_d = hm0_q;
    pv_d  = pend_v;
    pa_d  = pend_addr;
    pw0_d = pend_w0;
    pw1_d = pend_w1;
    pm0_d = pend_m0;
    pm1_d = pend_m1;
    if (is_pri) begin
      act_d = !wr_sel_n;
      if (!wr_sel_n) begin
        hw0_d = wdata;
        hm0_d = ~wbe_n;
      end
    end else begin
      pv_d = act_q;
      if (act_q) begin
        pa_d  = addr;
        pw0_d = hw0_q;
        pm0_d = hm0_q;
        pw1_d = wdata;
        pm1_d = ~wbe_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      hw0_q     <= '0;
      hm0_q     <= '0;
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_w0   <= '0;
      pend_w1   <= '0;
      pend_m0   <= '0;
      pend_m1   <= '0;
    end else begin
      act_q     <= act_d;
      hw0_q     <= hw0_d;
      hm0_q     <= hm0_d;
      pend_v    <= pv_d;
      pend_addr <= pa_d;
      pend_w0   <= pw0_d;
      pend_w1   <= pw1_d;
      pend_m0   <= pm0_d;
      pend_m1   <= pm1_d;
    end
  end

endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic                     fwd_v,
  input  logic [ADDR_W-1:0]        c_addr,
  input  logic [BYTE_W*NBYTE-1:0]  c_w0,
  input  logic [BYTE_W*NBYTE-1:0]  c_w1,
  input  logic [NBYTE-1:0]         c_m0,
  input  logic [NBYTE-1:0]         c_m1,
  input  logic [ADDR_W-1:0]        r_addr,
  output logic [BYTE_W*NBYTE-1:0]  r_w0,
  output logic [BYTE_W*NBYTE-1:0]  r_w1
);

  localparam int WORD_W = BYTE_W * NBYTE;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem0 [DEPTH];
  logic [WORD_W-1:0] mem1 [DEPTH];
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem0[i] <= '0;
        mem1[i] <= '0;
      end
    end else if (commit) begin
      for (int j = 0; j < NBYTE; j++) begin
        if (c_m0[j]) mem0[c_addr][j*BYTE_W +: BYTE_W] <= c_w0[j*BYTE_W +: BYTE_W];
        if (c_m1[j]) mem1[c_addr][j*BYTE_W +: BYTE_W] <= c_w1[j*BYTE_W +: BYTE_W];
      end
    end
  end

  assign hit = fwd_v && (c_addr == r_addr);

  // Per-byte merge: enabled bytes of the pending write take precedence over the array.
  for (genvar g = 0; g < NBYTE; g++) begin : g_merge
    assign r_w0[g*BYTE_W +: BYTE_W] = (hit && c_m0[g]) ? c_w0[g*BYTE_W +: BYTE_W]
                                                       : mem0[r_addr][g*BYTE_W +: BYTE_W];
    assign r_w1[g*BYTE_W +: BYTE_W] = (hit && c_m1[g]) ? c_w1[g*BYTE_W +: BYTE_W]
                                                       : mem1[r_addr][g*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_pri,
  input  logic              lat_long,
  input  logic              rd_go,
  input  logic [WORD_W-1:0] rd_w0,
  input  logic [WORD_W-1:0] rd_w1,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              rstrobe
);

  // Stage a loads at primary beats, b at secondary beats, c at primary beats.
  logic              a_v, b_v, c_v;
  logic [WORD_W-1:0] a_w0, a_w1, b_w0, b_w1, c_w0, c_w1;
  logic              a_v_d, b_v_d, c_v_d;
  logic [WORD_W-1:0] a_w0_d, a_w1_d, b_w0_d, b_w1_d, c_w0_d, c_w1_d;
  logic              o_v_d, o_s_d;
  logic [WORD_W-1:0] o_w_d, o_sel;

  always_comb begin
    a_v_d = a_v;  a_w0_d = a_w0;  a_w1_d = a_w1;
    b_v_d = b_v;  b_w0_d = b_w0;  b_w1_d = b_w1;
    c_v_d = c_v;  c_w0_d = c_w0;  c_w1_d = c_w1;
    if (is_pri) begin
      a_v_d = rd_go;
      if (rd_go) begin
        a_w0_d = rd_w0;
        a_w1_d = rd_w1;
      end
      c_v_d  = b_v;
      c_w0_d = b_w0;
      c_w1_d = b_w1;
      o_v_d  = lat_long ? c_v  : b_v;
      o_sel  = lat_long ? c_w1 : b_w0;
    end else begin
      b_v_d  = a_v;
      b_w0_d = a_w0;
      b_w1_d = a_w1;
      o_v_d  = lat_long ? c_v  : b_v;
      o_sel  = lat_long ? c_w0 : b_w1;
    end
    o_w_d = o_v_d ? o_sel : '0;
    o_s_d = rstrobe ^ o_v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v <= 1'b0;  a_w0 <= '0;  a_w1 <= '0;
      b_v <= 1'b0;  b_w0 <= '0;  b_w1 <= '0;
      c_v <= 1'b0;  c_w0 <= '0;  c_w1 <= '0;
      rvalid  <= 1'b0;
      rdata   <= '0;
      rstrobe <= 1'b0;
    end else begin
      a_v <= a_v_d;  a_w0 <= a_w0_d;  a_w1 <= a_w1_d;
      b_v <= b_v_d;  b_w0 <= b_w0_d;  b_w1 <= b_w1_d;
      c_v <= c_v_d;  c_w0 <= c_w0_d;  c_w1 <= c_w1_d;
      rvalid  <= o_v_d;
      rdata   <= o_w_d;
      rstrobe <= o_s_d;
    end
  end

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 2,
  localparam int WORD_W = BYTE_W * NBYTE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_long,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NBYTE-1:0]  wbe_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              rstrobe,
  output logic              beat_k
);

  logic              is_pri;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_w0, pend_w1;
  logic [NBYTE-1:0]  pend_m0, pend_m1;
  logic [WORD_W-1:0] rd_w0, rd_w1;
  logic              rd_go;
  logic              commit;

  qdr_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .is_pri (is_pri)
  );

  qdr_wr_stage #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_pri    (is_pri),
    .wr_sel_n  (wr_sel_n),
    .addr      (addr),
    .wdata     (wdata),
    .wbe_n     (wbe_n),
    .pend_v    (pend_v),
    .pend_addr (pend_addr),
    .pend_w0   (pend_w0),
    .pend_w1   (pend_w1),
    .pend_m0   (pend_m0),
    .pend_m1   (pend_m1)
  );

  // The pending write lands at the primary beat that follows its completion.
  assign commit = is_pri && pend_v;
  assign rd_go  = is_pri && !rd_sel_n;

  qdr_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .fwd_v  (pend_v),
    .c_addr (pend_addr),
    .c_w0   (pend_w0),
    .c_w1   (pend_w1),
    .c_m0   (pend_m0),
    .c_m1   (pend_m1),
    .r_addr (addr),
    .r_w0   (rd_w0),
    .r_w1   (rd_w1)
  );

  qdr_rd_pipe #(.WORD_W(WORD_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_pri   (is_pri),
    .lat_long (lat_long),
    .rd_go    (rd_go),
    .rd_w0    (rd_w0),
    .rd_w1    (rd_w1),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .rstrobe  (rstrobe)
  );

  assign beat_k = is_pri;

endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lat_long,
  input logic              rd_sel_n,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid,
  input logic              rstrobe,
  input logic              beat_k
);

  assert_beat_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (beat_k != $past(beat_k)));

  assert_short_read_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_k && !rd_sel_n && !lat_long) |-> ##3 rvalid ##1 rvalid);

  assert_long_read_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_k && !rd_sel_n && lat_long) |-> ##4 rvalid ##1 rvalid);

  assert_burst_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid);

  assert_short_idle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_k && rd_sel_n && !lat_long) |-> ##3 !rvalid ##1 !rvalid);

  assert_long_idle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_k && rd_sel_n && lat_long) |-> ##4 !rvalid ##1 !rvalid);

  assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));

  assert_strobe_toggles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rstrobe != $past(rstrobe)));

  assert_strobe_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> $stable(rstrobe));

endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lat_long (lat_long),
  .rd_sel_n (rd_sel_n),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .rstrobe  (rstrobe),
  .beat_k   (beat_k)
);

// File: tb/qdr_burst_sram_bench.sv
module qdr_burst_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int BW    = 9;
  localparam int NB    = 2;
  localparam int WW    = BW * NB;
  localparam int DEPTH = 1 << AW;
  localparam int NC    = 200;
  localparam int NBEAT = 2 * NC + 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lat_long;
  logic          rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] wdata;
  logic [NB-1:0] wbe_n;
  logic [WW-1:0] rdata;
  logic          rvalid, rstrobe, beat_k;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdr_burst_sram #(.ADDR_W(AW), .BYTE_W(BW), .NBYTE(NB)) u_qdr_burst_sram (
    .clk(clk), .rst_n(rst_n), .lat_long(lat_long), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
    .rdata(rdata), .rvalid(rvalid), .rstrobe(rstrobe), .beat_k(beat_k)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [WW-1:0] mm0 [DEPTH];
  logic [WW-1:0] mm1 [DEPTH];
  bit            part [DEPTH];
  logic          exp_v [NBEAT];
  logic [WW-1:0] exp_d [NBEAT];
  string         exp_r [NBEAT];
  logic          exp_s;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] nw,
                                          input logic [NB-1:0] m);
    logic [WW-1:0] r = old;
    for (int j = 0; j < NB; j++)
      if (m[j]) r[j*BW +: BW] = nw[j*BW +: BW];
    return r;
  endfunction

  task automatic run(input bit lng);
    bit rd, wr, stray, prev_wr;
    logic [AW-1:0] ra, wa, prev_wa;
    logic [WW-1:0] d0, d1;
    logic [NB-1:0] m0, m1;
    int lat;
    rst_n = 1'b0; lat_long = lng;
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0; wdata = '0; wbe_n = '1;
    for (int i = 0; i < DEPTH; i++) begin mm0[i] = '0; mm1[i] = '0; part[i] = 0; end
    for (int i = 0; i < NBEAT; i++) begin exp_v[i] = 0; exp_d[i] = '0; exp_r[i] = "R9"; end
    exp_s = 0; prev_wr = 0; prev_wa = '0; stray = 0;
    rd = 0; wr = 0; ra = '0; wa = '0; d0 = '0; d1 = '0; m0 = '0; m1 = '0;
    lat = lng ? 3 : 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the port
    check(rvalid == 0 && rdata == '0 && rstrobe == 0, "R1", "reset outputs",
          {rvalid, rstrobe, 12'h0, rdata}, 32'h0);
    check(beat_k == 1, "R1", "first beat primary", 32'(beat_k), 32'h1);
    for (int b = 0; b < NBEAT; b++) begin
      int n = b / 2;
      if (b % 2 == 0) begin
        if (n < NC) begin
          rd    = (n < 8) ? 1 : (n % 4 != 1);
          wr    = (n < 8) ? 0 : (n % 5 != 3);
          stray = (n % 6 == 5);
          wa    = AW'(n * 13 + 5);
          if (n < 8)          ra = AW'(n * 9);
          else if (n % 3 == 0) ra = prev_wa;
          else if (n % 7 == 2) ra = wa;
          else                 ra = AW'(n * 29 + 3);
          d0 = WW'(n * 2477 + 17);
          d1 = WW'((n * 911) ^ 18'h2aaaa);
          m0 = (n % 6 < 3) ? 2'b11 : 2'(n % 4);
          m1 = (n % 6 < 3) ? 2'b11 : 2'((n / 4) % 4);
          if (rd) begin
            string t;
            if (n < 8)                      t = "R1";
            else if (prev_wr && ra == prev_wa) t = "R6";
            else if (wr && ra == wa)        t = "R7";
            else if (part[ra])              t = "R5";
            else if (wr)                    t = "R11";
            else                            t = lng ? "R4" : "R3";
            exp_v[2*n+lat] = 1; exp_d[2*n+lat] = mm0[ra]; exp_r[2*n+lat] = t;
            exp_v[2*n+lat+1] = 1; exp_d[2*n+lat+1] = mm1[ra]; exp_r[2*n+lat+1] = t;
          end else if (stray) begin
            exp_r[2*n+lat] = "R8"; exp_r[2*n+lat+1] = "R8";
          end
          if (wr) begin
            mm0[wa] = merge(mm0[wa], d0, m0);
            mm1[wa] = merge(mm1[wa], d1, m1);
            if (m0 != 2'b11 || m1 != 2'b11) part[wa] = 1;
          end
          prev_wa = wa; prev_wr = wr;
          rd_sel_n = !rd; wr_sel_n = !wr; addr = ra; wdata = d0; wbe_n = ~m0;
        end else begin
          rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0; wdata = '0; wbe_n = '1;
        end
      end else begin
        if (n < NC) begin
          // R8: selects driven low at secondary beats must start nothing
          rd_sel_n = stray ? 1'b0 : 1'b1;
          wr_sel_n = stray ? 1'b0 : 1'b1;
          addr = wa; wdata = d1; wbe_n = ~m1;
        end else begin
          rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        end
      end
      @(negedge clk);
      if (exp_v[b])
        check(rvalid == 1 && rdata == exp_d[b], exp_r[b], "read beat",
              {13'h0, rvalid, rdata}, {13'h0, 1'b1, exp_d[b]});
      else
        check(rvalid == 0 && rdata == '0, exp_r[b], "idle beat",
              {13'h0, rvalid, rdata}, 32'h0);
      exp_s = exp_s ^ exp_v[b];
      check(rstrobe == exp_s, "R10", "strobe", 32'(rstrobe), 32'(exp_s));
      check(beat_k == (b % 2 == 1), "R2", "beat phase", 32'(beat_k), 32'(b % 2 == 1));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    run(1'b0);
    run(1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule